// File: doc/BRIEF.md
# Deferred floating-point trap sequencer

This block sits beside the issue stage of a 32-bit integer core whose floating-point unit reports faults late. It follows the FPU through three exception states: running normally, holding a fault that has not yet been reported, and reporting it. It keeps a one-deep fault queue that holds the address and the instruction word of the FPop that faulted. For each FP-class instruction offered on the issue strobe, it decides in the same cycle whether a trap is taken and which one.

When a faulting FPop issues, no trap is taken at that point. The next FPop takes the FP-exception trap. From then on the queue is marked non-empty, and only stores may run until a store-queue instruction drains the entry. Any other FP operation in that window is a sequence error. When an FP-exception trap is taken, the block also gives the redirected program counter pair, as if the following instruction had trapped. Arithmetic and memory traffic are handled elsewhere. On a drain, the block only presents the 64-bit word and a write strobe.

Top module: `fpq_trap_ctl`

## Requirements
- R1: After reset, no trap is signalled, the status word is zero (queue-not-empty bit 13 clear, fault-type field bits 16:14 equal to 0) and the queue word is zero.
- R2: In the normal state, an FPop (class code 0) with `fp_fault` high takes no trap. It records its address and instruction word in the queue, and the FPU enters the fault-held state.
- R3: In the fault-held state with the queue empty, the next FPop takes the FP-exception trap (kind 4) and sets status bit 13 one edge later. The queue word holds the recorded address in bits 63:32 and the instruction word in bits 31:0.
- R4: While bit 13 is set, an FPop, FP load (1), FP branch (2) or status load (4) takes the FP-exception trap, sets the fault-type field to sequence error (code 4) and leaves the queue word unchanged.
- R5: An FP store (3) or status store (5) only traps when the FPU is disabled (kind 3), in every state, and changes neither the status word nor the queue word.
- R6: A store-queue instruction (6) with bit 13 set takes no trap and pulses `q_wr_en` with the queue word on `q_word`. Bit 13 is clear one edge later, and the FPU returns to the normal state, so a following FPop without a fault takes no trap.
- R7: A store-queue instruction with bit 13 clear takes the FP-exception trap and sets the fault-type field to 4.
- R8: For a store-queue instruction the trap priority is: illegal encoding (kind 1), then not supervisor (kind 2), then FPU disabled (kind 3), then queue empty (kind 4).
- R9: For classes 0 to 5, FPU disabled (kind 3) wins over the sequence-error check, and such an instruction leaves status and queue unchanged.
- R10: Whenever kind 4 is signalled, `redir_pc` equals the offered next PC and `redir_npc` equals that next PC plus 4.
- R11: With `insn_valid` low, or with class code 7, the kind is 0, `trap_req` is low and no state changes.
- R12: In the fault-held state, FP loads, FP branches and status loads take no trap. Only an FPop delivers the deferred trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | An instruction is offered this cycle |
| insn_class | input | 3 | FP class code (0 FPop, 1 load, 2 branch, 3 store, 4 status load, 5 status store, 6 store-queue, 7 none) |
| insn_pc | input | ADDR_W | Address of the offered instruction |
| insn_npc | input | ADDR_W | Next PC of the offered instruction |
| insn_word | input | 32 | Instruction word |
| is_super | input | 1 | Supervisor mode |
| fpu_en | input | 1 | FPU enabled |
| enc_illegal | input | 1 | Store-queue address field is illegally encoded |
| fp_fault | input | 1 | The offered FPop raises an FP fault |
| trap_req | output | 1 | A trap is taken this cycle |
| trap_kind | output | 3 | 0 none, 1 illegal, 2 privileged, 3 FP disabled, 4 FP exception |
| redir_pc | output | ADDR_W | PC to use when the FP-exception trap is taken |
| redir_npc | output | ADDR_W | Next PC to use when the FP-exception trap is taken |
| fsr_status | output | 32 | Status slice: bit 13 queue not empty, bits 16:14 fault type |
| q_word | output | 64 | Queue entry: address high, instruction low |
| q_wr_en | output | 1 | Queue entry is being stored this cycle |

## Verification
The trap decision, `q_wr_en` and the redirect pair are combinational from the offered instruction and the current state, so they are due in the same cycle that the instruction is offered. Status bits and the queue word are due one clock edge later. The bench drives each instruction just after a falling edge and compares shortly afterwards. The expected item for that cycle holds the trap outcome and the status as it stands before the coming edge. The reference model is updated only after the item is queued, so every registered result is checked in the cycle that follows its update.

// File: rtl/fpq_pkg.sv
package fpq_pkg;
   typedef enum logic [2:0] {
      CL_FPOP  = 3'd0,
      CL_FLD   = 3'd1,
      CL_FBR   = 3'd2,
      CL_FST   = 3'd3,
      CL_LDFSR = 3'd4,
      CL_STFSR = 3'd5,
      CL_STQ   = 3'd6,
      CL_NONE  = 3'd7
   } fp_class_e;

   typedef enum logic [2:0] {
      TK_NONE  = 3'd0,
      TK_ILL   = 3'd1,
      TK_PRIV  = 3'd2,
      TK_FPDIS = 3'd3,
      TK_FPEXC = 3'd4
   } trap_kind_e;

   typedef enum logic [1:0] {
      FS_RUN  = 2'd0,
      FS_HELD = 2'd1,
      FS_RPT  = 2'd2
   } fpu_state_e;

   typedef struct packed {
      logic capture;   // faulting FPop recorded
      logic enqueue;   // deferred trap delivered, queue marked full
      logic seq_err;   // sequence error, fault type updated
      logic repend;    // back to fault-held state
      logic drain;     // queue stored and emptied
   } fpq_act_t;

   localparam logic [2:0] FTT_SEQ_ERR = 3'd4;
   localparam int QNE_POS = 13;
   localparam int FTT_LSB = 14;
endpackage

// File: rtl/fpq_decide.sv
module fpq_decide
   import fpq_pkg::*;
(
   input  logic       valid,
   input  fp_class_e  cls,
   input  logic       sup,
   input  logic       en,
   input  logic       illegal,
   input  logic       fault,
   input  fpu_state_e state,
   input  logic       qne,
   output trap_kind_e kind,
   output fpq_act_t   act
);
   always_comb begin
      kind = TK_NONE;
      act  = '0;
      if (valid) begin
         case (cls)
            CL_STQ: begin
               if (illegal)      kind = TK_ILL;
               else if (!sup)    kind = TK_PRIV;
               else if (!en)     kind = TK_FPDIS;
               else if (!qne) begin
                  kind        = TK_FPEXC;
                  act.seq_err = 1'b1;
               end else begin
                  act.drain   = 1'b1;
               end
            end
            CL_FST, CL_STFSR: begin
               if (!en) kind = TK_FPDIS;
            end
            CL_FPOP, CL_FLD, CL_FBR, CL_LDFSR: begin
               if (!en) kind = TK_FPDIS;
               else if (qne) begin
                  kind        = TK_FPEXC;
                  act.seq_err = 1'b1;
                  act.repend  = 1'b1;
               end else if (cls == CL_FPOP) begin
                  if (state == FS_HELD) begin
                     kind        = TK_FPEXC;
                     act.enqueue = 1'b1;
                  end else if (state == FS_RUN && fault) begin
                     act.capture = 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/fpq_fsm.sv
module fpq_fsm
   import fpq_pkg::*;
#(
   parameter int FTT_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  fpq_act_t         act,
   output fpu_state_e       state,
   output logic             qne,
   output logic [FTT_W-1:0] ftt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= FS_RUN;
         qne   <= 1'b0;
         ftt   <= '0;
      end else begin
         if (act.capture) state <= FS_HELD;
         if (act.enqueue) begin
            state <= FS_RPT;
            qne   <= 1'b1;
         end
         if (act.seq_err) ftt   <= FTT_W'(FTT_SEQ_ERR);
         if (act.repend)  state <= FS_HELD;
         if (act.drain) begin
            qne   <= 1'b0;
            state <= FS_RUN;
         end
      end
   end
endmodule

// File: rtl/fpq_store.sv
module fpq_store #(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [ADDR_W-1:0]   addr_in,
   input  logic [WORD_W-1:0]   word_in,
   output logic [2*WORD_W-1:0] entry
);
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         word_q <= '0;
      end else if (load) begin
         addr_q <= addr_in;
         word_q <= word_in;
      end
   end

   generate
      if (ADDR_W == WORD_W) begin : g_full
         assign entry = {addr_q, word_q};
      end else begin : g_pad
         assign entry = {{(WORD_W-ADDR_W){1'b0}}, addr_q, word_q};
      end
   endgenerate
endmodule

// File: rtl/fpq_trap_ctl.sv
module fpq_trap_ctl
   import fpq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32,
   parameter int STAT_W = 32
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                insn_valid,
   input  logic [2:0]          insn_class,
   input  logic [ADDR_W-1:0]   insn_pc,
   input  logic [ADDR_W-1:0]   insn_npc,
   input  logic [WORD_W-1:0]   insn_word,
   input  logic                is_super,
   input  logic                fpu_en,
   input  logic                enc_illegal,
   input  logic                fp_fault,
   output logic                trap_req,
   output logic [2:0]          trap_kind,
   output logic [ADDR_W-1:0]   redir_pc,
   output logic [ADDR_W-1:0]   redir_npc,
   output logic [STAT_W-1:0]   fsr_status,
   output logic [2*WORD_W-1:0] q_word,
   output logic                q_wr_en
);
   localparam int FTT_W   = 3;
   localparam int STEP    = 4;
   localparam int STAT_HI = FTT_LSB + FTT_W - 1;

   generate
      if (ADDR_W < 3 || ADDR_W > WORD_W) begin : g_bad_addr
         $error("fpq_trap_ctl: ADDR_W must lie in 3..WORD_W");
      end
      if (STAT_W <= STAT_HI) begin : g_bad_stat
         $error("fpq_trap_ctl: STAT_W too narrow for the fault-type field");
      end
   endgenerate

   fpu_state_e       state;
   logic             qne;
   logic [FTT_W-1:0] ftt;
   trap_kind_e       kind;
   fpq_act_t         act;

   fpq_decide u_decide (
      .valid   (insn_valid),
      .cls     (fp_class_e'(insn_class)),
      .sup     (is_super),
      .en      (fpu_en),
      .illegal (enc_illegal),
      .fault   (fp_fault),
      .state   (state),
      .qne     (qne),
      .kind    (kind),
      .act     (act)
   );

   fpq_fsm #(.FTT_W(FTT_W)) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (act),
      .state (state),
      .qne   (qne),
      .ftt   (ftt)
   );

   fpq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (act.capture),
      .addr_in (insn_pc),
      .word_in (insn_word),
      .entry   (q_word)
   );

   always_comb begin
      fsr_status                  = '0;
      fsr_status[QNE_POS]         = qne;
      fsr_status[STAT_HI:FTT_LSB] = ftt;
   end

   assign trap_kind = kind;
   assign trap_req  = (kind != TK_NONE);
   assign q_wr_en   = act.drain;
   assign redir_pc  = insn_npc;
   assign redir_npc = insn_npc + ADDR_W'(STEP);
endmodule

// File: rtl/fpq_trap_ctl_chk.sv
module fpq_trap_ctl_chk #(
   parameter int ADDR_W = 32,
   parameter int STAT_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              insn_valid,
   input logic [2:0]        insn_class,
   input logic              enc_illegal,
   input logic              trap_req,
   input logic [2:0]        trap_kind,
   input logic [ADDR_W-1:0] redir_pc,
   input logic [ADDR_W-1:0] redir_npc,
   input logic [STAT_W-1:0] fsr_status,
   input logic              q_wr_en
);
   a_r11_idle_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_valid |-> (trap_kind == 3'd0 && !trap_req));

   a_r5_store_only_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && (insn_class == 3'd3 || insn_class == 3'd5))
      |-> (trap_kind == 3'd0 || trap_kind == 3'd3));

   a_r8_illegal_first: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_class == 3'd6 && enc_illegal) |-> trap_kind == 3'd1);

   a_r6_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
      q_wr_en |=> !fsr_status[13]);

   a_r3_qne_from_fpop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsr_status[13]) |->
      $past(insn_valid && insn_class == 3'd0 && trap_kind == 3'd4));

   a_r4_seq_err_type: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && (insn_class == 3'd1 || insn_class == 3'd2 || insn_class == 3'd4)
       && trap_kind == 3'd4) |=> fsr_status[16:14] == 3'd4);

   a_r10_redirect_step: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_kind == 3'd4) |-> (redir_npc == redir_pc + ADDR_W'(4)));
endmodule

bind fpq_trap_ctl fpq_trap_ctl_chk #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .insn_valid  (insn_valid),
   .insn_class  (insn_class),
   .enc_illegal (enc_illegal),
   .trap_req    (trap_req),
   .trap_kind   (trap_kind),
   .redir_pc    (redir_pc),
   .redir_npc   (redir_npc),
   .fsr_status  (fsr_status),
   .q_wr_en     (q_wr_en)
);

// File: tb/fpq_trap_ctl_bench.sv
`timescale 1ns/1ps
module fpq_trap_ctl_bench;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          insn_valid = 1'b0;
   logic [2:0]    insn_class = 3'd7;
   logic [AW-1:0] insn_pc = '0;
   logic [AW-1:0] insn_npc = '0;
   logic [31:0]   insn_word = '0;
   logic          is_super = 1'b1;
   logic          fpu_en = 1'b1;
   logic          enc_illegal = 1'b0;
   logic          fp_fault = 1'b0;
   logic          trap_req;
   logic [2:0]    trap_kind;
   logic [AW-1:0] redir_pc, redir_npc;
   logic [31:0]   fsr_status;
   logic [63:0]   q_word;
   logic          q_wr_en;

   always #2.5 clk = ~clk;

   fpq_trap_ctl u_fpq_trap_ctl (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_class(insn_class),
      .insn_pc(insn_pc), .insn_npc(insn_npc), .insn_word(insn_word),
      .is_super(is_super), .fpu_en(fpu_en), .enc_illegal(enc_illegal),
      .fp_fault(fp_fault), .trap_req(trap_req), .trap_kind(trap_kind),
      .redir_pc(redir_pc), .redir_npc(redir_npc), .fsr_status(fsr_status),
      .q_word(q_word), .q_wr_en(q_wr_en)
   );

   typedef struct {
      logic [2:0]    kind;
      logic          wr;
      logic          qne;
      logic [2:0]    ftt;
      logic [63:0]   qw;
      logic [AW-1:0] rpc;
      logic [AW-1:0] rnpc;
      string         tag;
   } exp_t;

   exp_t exp_q[$];
   int n_cmp = 0;
   int n_bad = 0;

   // reference state: 0 normal, 1 fault held, 2 reporting
   int          m_state = 0;
   logic        m_qne = 1'b0;
   logic [2:0]  m_ftt = 3'd0;
   logic [63:0] m_qw = '0;

   task automatic issue(input logic v, input logic [2:0] c, input logic [31:0] pc,
                        input logic [31:0] w, input logic sup, input logic en,
                        input logic ill, input logic flt, input string tag);
      exp_t e;
      logic [2:0] k;
      logic wr;
      @(negedge clk);
      insn_valid = v; insn_class = c; insn_pc = pc; insn_npc = pc + 32'd4;
      insn_word = w; is_super = sup; fpu_en = en; enc_illegal = ill; fp_fault = flt;
      k = 3'd0; wr = 1'b0;
      e.qne = m_qne; e.ftt = m_ftt; e.qw = m_qw;
      if (v) begin
         if (c == 3'd6) begin
            if (ill) k = 3'd1;
            else if (!sup) k = 3'd2;
            else if (!en) k = 3'd3;
            else if (!m_qne) begin k = 3'd4; m_ftt = 3'd4; end
            else begin wr = 1'b1; m_qne = 1'b0; m_state = 0; end
         end else if (c == 3'd3 || c == 3'd5) begin
            if (!en) k = 3'd3;
         end else if (c != 3'd7) begin
            if (!en) k = 3'd3;
            else if (m_qne) begin k = 3'd4; m_ftt = 3'd4; m_state = 1; end
            else if (c == 3'd0) begin
               if (m_state == 1) begin k = 3'd4; m_qne = 1'b1; m_state = 2; end
               else if (m_state == 0 && flt) begin m_qw = {pc, w}; m_state = 1; end
            end
         end
      end
      e.kind = k; e.wr = wr; e.rpc = pc + 32'd4; e.rnpc = pc + 32'd8; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] got, input logic [63:0] want);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, want);
      end
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(trap_kind == e.kind, e.tag, "trap_kind", 64'(trap_kind), 64'(e.kind));
            chk(trap_req == (e.kind != 3'd0), e.tag, "trap_req", 64'(trap_req), 64'(e.kind != 3'd0));
            chk(q_wr_en == e.wr, e.tag, "q_wr_en", 64'(q_wr_en), 64'(e.wr));
            chk(fsr_status[13] == e.qne, e.tag, "qne bit13", 64'(fsr_status[13]), 64'(e.qne));
            chk(fsr_status[16:14] == e.ftt, e.tag, "ftt", 64'(fsr_status[16:14]), 64'(e.ftt));
            chk(q_word == e.qw, e.tag, "q_word", q_word, e.qw);
            if (e.kind == 3'd4) begin
               chk(redir_pc == e.rpc, e.tag, "redir_pc", 64'(redir_pc), 64'(e.rpc));
               chk(redir_npc == e.rnpc, e.tag, "redir_npc", 64'(redir_npc), 64'(e.rnpc));
            end
         end
      end
   end

   task automatic run_all();
      // R1 reset state
      issue(0, 3'd7, 32'h0, 32'h0, 1, 1, 0, 0, "R1");
      issue(0, 3'd0, 32'h0, 32'h0, 1, 1, 0, 0, "R1");
      // R5 stores in normal state
      issue(1, 3'd5, 32'h40, 32'h11, 1, 1, 0, 0, "R5");
      issue(1, 3'd3, 32'h44, 32'h12, 1, 0, 0, 0, "R5");
      // R7 store-queue on empty queue
      issue(1, 3'd6, 32'h48, 32'h13, 1, 1, 0, 0, "R7");
      issue(1, 3'd0, 32'h4C, 32'h14, 1, 1, 0, 0, "R2");
      // R2 faulting FPop deferred
      issue(1, 3'd0, 32'h100, 32'hA1B2C3D4, 1, 1, 0, 1, "R2");
      // R12 non-FPops do not deliver
      issue(1, 3'd1, 32'h104, 32'h21, 1, 1, 0, 0, "R12");
      issue(1, 3'd2, 32'h108, 32'h22, 1, 1, 0, 0, "R12");
      issue(1, 3'd4, 32'h10C, 32'h23, 1, 1, 0, 0, "R12");
      issue(1, 3'd3, 32'h110, 32'h24, 1, 1, 0, 0, "R5");
      issue(1, 3'd0, 32'h114, 32'h25, 1, 0, 0, 0, "R9");
      // R3 / R10 deferred delivery
      issue(1, 3'd0, 32'h118, 32'h26, 1, 1, 0, 1, "R3");
      issue(0, 3'd7, 32'h0, 32'h0, 1, 1, 0, 0, "R3");
      // R4 sequence errors
      issue(1, 3'd0, 32'h200, 32'h31, 1, 1, 0, 0, "R4");
      issue(1, 3'd1, 32'h204, 32'h32, 1, 1, 0, 0, "R4");
      issue(1, 3'd2, 32'h208, 32'h33, 1, 1, 0, 0, "R4");
      issue(1, 3'd4, 32'h20C, 32'h34, 1, 1, 0, 0, "R10");
      issue(1, 3'd1, 32'h210, 32'h35, 1, 0, 0, 0, "R9");
      issue(1, 3'd5, 32'h214, 32'h36, 1, 1, 0, 0, "R5");
      // R8 store-queue priority
      issue(1, 3'd6, 32'h218, 32'h37, 0, 0, 1, 0, "R8");
      issue(1, 3'd6, 32'h21C, 32'h38, 0, 0, 0, 0, "R8");
      issue(1, 3'd6, 32'h220, 32'h39, 1, 0, 0, 0, "R8");
      // R11 ignored stimulus
      issue(1, 3'd7, 32'h224, 32'h3A, 1, 1, 0, 1, "R11");
      issue(0, 3'd0, 32'h228, 32'h3B, 1, 1, 0, 1, "R11");
      // R6 drain
      issue(1, 3'd6, 32'h22C, 32'h3C, 1, 1, 0, 0, "R6");
      issue(1, 3'd0, 32'h230, 32'h3D, 1, 1, 0, 0, "R6");
      issue(1, 3'd4, 32'h234, 32'h3E, 1, 1, 0, 0, "R6");
      // second round
      issue(1, 3'd0, 32'h300, 32'hDEADBEEF, 1, 1, 0, 1, "R2");
      issue(1, 3'd0, 32'h304, 32'h41, 1, 1, 0, 0, "R3");
      issue(1, 3'd6, 32'h308, 32'h42, 1, 1, 0, 0, "R6");
      issue(0, 3'd7, 32'h0, 32'h0, 1, 1, 0, 0, "R6");
      issue(0, 3'd7, 32'h0, 32'h0, 1, 1, 0, 0, "R1");
   endtask

   initial begin : main
      bit timed_out;
      timed_out = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      fork
         begin
            run_all();
            repeat (3) @(posedge clk);
         end
         begin
            repeat (200000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule